// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms a 32-bit linear memory address from four parts: a segment base, a base register value, an index register value scaled by a power of two, and a two's-complement displacement. The segment bases are not carried with the request. They sit in a small register file inside the unit, and the unit reads that file at the moment it accepts a request. A separate write port loads the file.

Issue logic presents the base, index, scale, displacement, a segment selector and a tag together, on a valid/ready handshake. The unit returns the address with the same tag as a one-cycle response pulse, in the order the requests were accepted. A request whose selected segment base is zero finishes in one cycle, and a new request can be accepted every cycle. A request whose base is nonzero needs one more cycle for the extra addition. During that cycle the unit holds ready low, so a later request cannot overtake it.

Top module: `seg_agu`

## Requirements
- R1: The response address equals segment base + base + (index << scale) + displacement, taken modulo 2^32. The displacement is a 32-bit two's-complement value.
- R2: The 2-bit scale field shifts the index left by its value: 0 gives ×1, 1 gives ×2, 2 gives ×4 and 3 gives ×8.
- R3: A request whose selected segment base is zero gives rsp_valid in the cycle after it is accepted. req_ready stays high, so consecutive cycles can each accept a request.
- R4: A request whose selected segment base is nonzero gives rsp_valid two cycles after acceptance. In the cycle between, req_ready and rsp_valid are both low.
- R5: Responses come out in acceptance order, and each carries the tag of its own request.
- R6: The segment file holds 6 entries, addressed by selector values 0 to 5. Selectors 6 and 7 read a base of zero and take the fast path. A write to 6 or 7 has no effect.
- R7: A segment write to entry k in the same cycle that a request with selector k is accepted takes effect for that request.
- R8: The segment base is captured at acceptance. A write to that entry during the request's extra cycle does not change the request's result.
- R9: A synchronous active-high reset clears every segment base to zero and drops any request in flight: after reset, rsp_valid is low and req_ready is high.
- R10: Each accepted request produces exactly one single-cycle rsp_valid pulse. rsp_valid is never high without an earlier acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment file write enable |
| seg_waddr | input | 3 | Segment entry written |
| seg_wdata | input | 32 | New segment base |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_tag | input | 4 | Request tag |
| req_seg | input | 3 | Segment selector |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_scale | input | 2 | Index shift amount |
| req_disp | input | 32 | Signed displacement |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | 4 | Tag of the response |
| rsp_addr | output | 32 | Linear address |

## Verification
The bench targets these corner cases:

- **Latency split.** A slow request is followed at once by a fast one. A design that let the fast request through during the held cycle would return the tags out of order.
- **Base changes around acceptance.** A write to the selected entry lands in the same cycle as acceptance, and another write lands during the extra cycle. A design that missed the forwarding would use the stale base. A design that re-read the file late would use the newer base.
- **Selectors 6 and 7.** Writes are aimed at these selectors, which must stay zero and fast.
- **Wrap-around.** Sums that cross 2^32 must wrap.
- **Reset with a request in flight.** Reset arrives during the extra cycle. A design that kept the request alive would still emit its response.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  parameter int ADDR_W  = 32;
  parameter int SCALE_W = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  // Sum of the three operands that travel with the request.
  function automatic addr_t agu_partial(addr_t base, addr_t index,
                                        logic [SCALE_W-1:0] scale, addr_t disp);
    return base + (index << scale) + disp;
  endfunction

  // Second-cycle addition of a nonzero segment base.
  function automatic addr_t agu_final(addr_t part, addr_t seg);
    return part + seg;
  endfunction
endpackage

// File: rtl/seg_file.sv
module seg_file
  import seg_agu_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  addr_t            wdata,
  input  logic [SEL_W-1:0] rsel,
  output addr_t            rbase
);
  addr_t ent [NSEG];

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst)                                ent[g] <= '0;
        else if (we && waddr == SEL_W'(g))      ent[g] <= wdata;
      end
    end
  endgenerate

  // Read with bypass of a same-cycle write; selectors past NSEG read zero.
  always_comb begin
    rbase = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (rsel == SEL_W'(i))
        rbase = (we && waddr == rsel) ? wdata : ent[i];
    end
  end

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rsel) >= NSEG) |-> (rbase == '0));
endmodule

// File: rtl/agu_stage.sv
module agu_stage
  import seg_agu_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  addr_t            in_part,
  input  addr_t            in_seg,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output addr_t            rsp_addr
);
  logic             hold_vld;
  addr_t            hold_part, hold_seg;
  logic [TAG_W-1:0] hold_tag;

  // Named events for the checks below.
  logic accept, acc_fast, acc_slow;
  assign in_ready = !hold_vld;
  assign accept   = in_valid && in_ready;
  assign acc_fast = accept && (in_seg == '0);
  assign acc_slow = accept && (in_seg != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_part <= '0;
      hold_seg  <= '0;
      hold_tag  <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (hold_vld) begin
        hold_vld  <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_tag   <= hold_tag;
        rsp_addr  <= agu_final(hold_part, hold_seg);
      end else if (acc_fast) begin
        rsp_valid <= 1'b1;
        rsp_tag   <= in_tag;
        rsp_addr  <= in_part;
      end else if (acc_slow) begin
        hold_vld  <= 1'b1;
        hold_part <= in_part;
        hold_seg  <= in_seg;
        hold_tag  <= in_tag;
      end
    end
  end

  // R3
  fast_latency_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fast |=> (rsp_valid && rsp_tag == $past(in_tag)));
  // R4
  slow_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    acc_slow |=> (!in_ready && !rsp_valid));
  // R4
  slow_finish_chk: assert property (@(posedge clk) disable iff (rst)
    hold_vld |=> (rsp_valid && in_ready));
  // R10
  no_orphan_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(acc_fast) || $past(hold_vld)));
  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && in_ready));
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int NSEG  = 6,
  parameter int SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seg_we,
  input  logic [SEL_W-1:0]   seg_waddr,
  input  logic [ADDR_W-1:0]  seg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [SEL_W-1:0]   req_seg,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [ADDR_W-1:0]  req_index,
  input  logic [SCALE_W-1:0] req_scale,
  input  logic [ADDR_W-1:0]  req_disp,
  output logic               rsp_valid,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic [ADDR_W-1:0]  rsp_addr
);
  addr_t seg_base, part_sum;

  seg_file #(.NSEG(NSEG), .SEL_W(SEL_W)) u_seg_file (
    .clk   (clk),
    .rst   (rst),
    .we    (seg_we),
    .waddr (seg_waddr),
    .wdata (seg_wdata),
    .rsel  (req_seg),
    .rbase (seg_base)
  );

  assign part_sum = agu_partial(req_base, req_index, req_scale, req_disp);

  agu_stage #(.TAG_W(TAG_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_tag    (req_tag),
    .in_part   (part_sum),
    .in_seg    (seg_base),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_addr  (rsp_addr)
  );
endmodule

// File: tb/seg_agu_bench.sv
module seg_agu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 1'b0;
  logic [2:0]  seg_waddr = '0;
  logic [31:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_tag = '0;
  logic [2:0]  req_seg = '0;
  logic [31:0] req_base = '0, req_index = '0, req_disp = '0;
  logic [1:0]  req_scale = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_tag;
  logic [31:0] rsp_addr;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  seg_agu u_seg_agu (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_waddr(seg_waddr), .seg_wdata(seg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_seg(req_seg),
    .req_base(req_base), .req_index(req_index), .req_scale(req_scale), .req_disp(req_disp),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_addr(rsp_addr)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] base;
    logic [31:0] idx;
    logic [1:0]  sc;
    logic [31:0] disp;
    logic [1:0]  lat;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 32'h100,        32'd3, 2'd0, 32'd4,        2'd1},
    '{3'd0, 32'h0,          32'd5, 2'd1, 32'd0,        2'd1},
    '{3'd0, 32'h0,          32'd5, 2'd2, 32'd0,        2'd1},
    '{3'd3, 32'h10,         32'd1, 2'd3, 32'hFFFFFFF8, 2'd1},
    '{3'd1, 32'h20,         32'd2, 2'd2, 32'd4,        2'd2},
    '{3'd2, 32'h2000,       32'd0, 2'd0, 32'd0,        2'd2},
    '{3'd5, 32'h80000000,   32'd0, 2'd0, 32'h10,       2'd2},
    '{3'd6, 32'h44,         32'd1, 2'd1, 32'd0,        2'd1},
    '{3'd7, 32'h0,          32'd0, 2'd0, 32'hFFFFFFFF, 2'd1},
    '{3'd4, 32'hFFFFFFFF,   32'd1, 2'd0, 32'd0,        2'd2}
  };

  // Bench-side address model: multiply instead of shift.
  function automatic logic [31:0] expect_addr(logic [31:0] sb, logic [31:0] b,
                                              logic [31:0] i, logic [1:0] s, logic [31:0] d);
    logic [63:0] sum;
    sum = 64'(sb) + 64'(b) + 64'(i) * (64'd1 << s) + 64'(d);
    return sum[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    seg_we = 1'b1; seg_waddr = a; seg_wdata = d;
    @(negedge clk);
    seg_we = 1'b0;
    if (a < 3'd6) model[a] = d;
  endtask

  // One request; optional same-cycle segment write.
  task automatic issue(input logic [2:0] sel, input logic [31:0] b, input logic [31:0] i,
                       input logic [1:0] s, input logic [31:0] d, input logic [3:0] tag,
                       input bit wen, input logic [2:0] wa, input logic [31:0] wd,
                       input int lat_exp, input string req);
    logic [31:0] exp_a;
    int n;
    @(negedge clk);
    if (wen && wa < 3'd6) model[wa] = wd;
    exp_a = expect_addr(model[sel], b, i, s, d);
    seg_we = wen; seg_waddr = wa; seg_wdata = wd;
    req_valid = 1'b1; req_seg = sel; req_base = b; req_index = i; req_scale = s;
    req_disp = d; req_tag = tag;
    check(req_ready == 1'b1, req, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0; seg_we = 1'b0;
    n = 1;
    if (lat_exp == 2) check(!req_ready && !rsp_valid, {req, " R4 bubble"},
                            64'({req_ready, rsp_valid}), 64'd0);
    while (!rsp_valid && n < 5) begin
      @(negedge clk);
      n++;
    end
    check(n == lat_exp, {req, " latency"}, 64'(n), 64'(lat_exp));
    check(rsp_addr == exp_a, {req, " addr"}, 64'(rsp_addr), 64'(exp_a));
    check(rsp_tag == tag, {req, " R5 tag"}, 64'(rsp_tag), 64'(tag));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!rsp_valid && req_ready, "R9 reset state", 64'({rsp_valid, req_ready}), 64'd1);

    seg_write(3'd1, 32'h1000);
    seg_write(3'd2, 32'hFFFFF000);
    seg_write(3'd4, 32'h10);
    seg_write(3'd5, 32'h80000000);

    // Table walk: R1 sums, R2 scales, R3/R4 latency, R6 unmapped selectors
    for (int v = 0; v < 10; v++)
      issue(VEC[v].sel, VEC[v].base, VEC[v].idx, VEC[v].sc, VEC[v].disp, 4'(v),
            1'b0, 3'd0, 32'd0, int'(VEC[v].lat), "R1 R2 R3 R4 R6 table");

    // R6: writes to selectors 6 and 7 are ignored
    seg_write(3'd6, 32'h555);
    seg_write(3'd7, 32'h777);
    issue(3'd6, 32'h8, 32'd0, 2'd0, 32'd0, 4'hA, 1'b0, 3'd0, 32'd0, 1, "R6 sel6");
    issue(3'd7, 32'h8, 32'd0, 2'd0, 32'd0, 4'hB, 1'b0, 3'd0, 32'd0, 1, "R6 sel7");

    // R7: same-cycle write forwarded
    issue(3'd3, 32'h1, 32'd0, 2'd0, 32'd0, 4'h3, 1'b1, 3'd3, 32'h300, 2, "R7 forward");
    // R7: write of zero on same cycle makes the request fast
    issue(3'd4, 32'h1, 32'd0, 2'd0, 32'd0, 4'h4, 1'b1, 3'd4, 32'h0, 1, "R7 zero forward");

    // R3/R5: back-to-back fast requests
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd0; req_base = 32'h40; req_index = 0; req_scale = 0;
    req_disp = 0; req_tag = 4'h1;
    @(negedge clk);
    check(rsp_valid && rsp_tag == 4'h1 && rsp_addr == 32'h40, "R3 b2b first",
          64'(rsp_addr), 64'h40);
    check(req_ready, "R3 ready stays high", 64'(req_ready), 64'd1);
    req_base = 32'h80; req_tag = 4'h2;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_tag == 4'h2 && rsp_addr == 32'h80, "R3 R5 b2b second",
          64'(rsp_tag), 64'h2);
    @(negedge clk);

    // R4/R5: slow then fast waiting behind it
    req_valid = 1'b1; req_seg = 3'd1; req_base = 32'h4; req_tag = 4'h5;
    @(negedge clk);
    check(!req_ready && !rsp_valid, "R4 hold cycle", 64'({req_ready, rsp_valid}), 64'd0);
    req_seg = 3'd0; req_base = 32'h9; req_tag = 4'h6;
    @(negedge clk);
    check(rsp_valid && rsp_tag == 4'h5 && rsp_addr == 32'h1004, "R5 slow first",
          64'(rsp_addr), 64'h1004);
    check(req_ready, "R4 ready back", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_tag == 4'h6 && rsp_addr == 32'h9, "R5 fast second",
          64'(rsp_tag), 64'h6);

    // R8: write during the extra cycle does not affect the held request
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd1; req_base = 32'h0; req_tag = 4'h7;
    @(negedge clk);
    req_valid = 1'b0;
    seg_we = 1'b1; seg_waddr = 3'd1; seg_wdata = 32'h2000;
    @(negedge clk);
    seg_we = 1'b0; model[1] = 32'h2000;
    check(rsp_valid && rsp_addr == 32'h1000, "R8 captured base", 64'(rsp_addr), 64'h1000);
    issue(3'd1, 32'h0, 32'd0, 2'd0, 32'd0, 4'h8, 1'b0, 3'd0, 32'd0, 2, "R8 new base later");

    // R9: reset during the extra cycle drops the request and clears bases
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd5; req_base = 32'h0; req_tag = 4'h9;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    check(!rsp_valid, "R9 dropped in flight", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 after reset", 64'({rsp_valid, req_ready}), 64'd1);
    issue(3'd5, 32'h12, 32'd0, 2'd0, 32'd0, 4'hC, 1'b0, 3'd0, 32'd0, 1, "R9 bases cleared");

    // R10: a single pulse per request and none while idle
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!rsp_valid, "R10 idle no pulse", 64'(rsp_valid), 64'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule